// File: doc/BRIEF.md
# Segment Hash Generator for a Hashed Page-Table Walk

This block sits between the segment lookaside stage of a 64-bit address translator and the page-table walker. For each request it takes an effective address together with the fields of the segment entry that the lookaside stage found, or a flag saying that no entry was found. From two per-entry flags it picks the segment size and the page size. It then derives the virtual segment identifier (VSID), the storage key for the current privilege level, the no-execute flag, the primary hash and the value that page-table entries are matched against.

A miss in the lookaside stage is not translated. It produces a distinct fault status, and every data output reads zero. Requests arrive over a valid/ready handshake and results leave over another, one cycle after acceptance. A two-state controller (EMPTY, FULL) holds one result. The controller moves from EMPTY to FULL when a request is accepted. It stays in FULL when the result is taken and a new request is accepted in the same cycle, or when the result is stalled. It goes from FULL back to EMPTY when the result is taken and no request arrives.

Top module: `seg_hash_gen`

## Requirements
- R1: When `req_hit` is 0, the result carries `rsp_status` = 4'b1011 (signed −5), and `rsp_vsid`, `rsp_key`, `rsp_noexec`, `rsp_hash` and `rsp_match` are all zero. A hit gives `rsp_status` = 0.
- R2: With `req_big_seg` = 0 (256 MB segment), `rsp_vsid` equals `req_vsid_field`. With `req_big_seg` = 1 (1 TB segment), `rsp_vsid` equals `req_vsid_field` shifted right by 12.
- R3: `rsp_key` equals `req_key_user` when `req_user` is 1 and `req_key_sup` when `req_user` is 0. `rsp_noexec` equals `req_noexec`.
- R4: The page address is `req_ea` ANDed with (2^S − 2^P). S is 28, or 40 when `req_big_seg` = 1. P is 12, or 24 when `req_big_page` = 1 (16 MB page). The page index is the page address shifted right by P.
- R5: For a 256 MB segment, `rsp_hash` is the low HASH_W (default 39) bits of VSID XOR page index.
- R6: For a 1 TB segment, `rsp_hash` is the low HASH_W bits of VSID XOR (VSID shifted left by 25, kept to 64 bits) XOR page index.
- R7: `rsp_match` equals `req_tag` ORed with ((page address >> 16) AND (2^S − 0x80)).
- R8: A request accepted at a clock edge (`req_valid` and `req_ready` both high) has its result on the outputs with `rsp_valid` high after that edge. `req_ready` is high whenever no result is held or the held result is being taken.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the result does not change. Results leave in acceptance order, with none lost and none repeated.
- R10: After reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_ea | input | EA_W (64) | Effective address |
| req_hit | input | 1 | A segment entry matched |
| req_big_seg | input | 1 | Entry describes a 1 TB segment |
| req_big_page | input | 1 | Entry describes 16 MB pages |
| req_vsid_field | input | VSID_W (52) | VSID field of the entry |
| req_key_user | input | 1 | Key bit used in user state |
| req_key_sup | input | 1 | Key bit used in supervisor state |
| req_noexec | input | 1 | Entry forbids instruction fetch |
| req_tag | input | EA_W (64) | Entry's match-value field |
| req_user | input | 1 | Processor is in user state |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Downstream takes result |
| rsp_status | output | 4 | 0 = translated, 4'b1011 = segment miss |
| rsp_vsid | output | VSID_W (52) | Extracted VSID |
| rsp_key | output | 1 | Selected storage key |
| rsp_noexec | output | 1 | No-execute flag |
| rsp_hash | output | HASH_W (39) | Primary hash |
| rsp_match | output | EA_W (64) | Page-table-entry match value |

## Verification
Two functions can fall in the same cycle: the output register hands a result downstream while a new request loads into it. The bench provokes this by sending requests back to back while `rsp_ready` follows a stall pattern, so the FULL state sees drain-and-load, drain-only and stall cycles. The scoreboard judges the result by comparing each result with its queued expectation, in acceptance order. A separate check confirms that stalled outputs do not change.

// File: rtl/shg_pkg.sv
package shg_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } shg_state_e;

    localparam logic [3:0] SHG_ST_OK   = 4'b0000;
    localparam logic [3:0] SHG_ST_MISS = 4'b1011;

endpackage

// File: rtl/shg_geom.sv
module shg_geom #(
    parameter int EA_W       = 64,
    parameter int SEG_SHORT  = 28,
    parameter int SEG_LONG   = 40,
    parameter int PG_SMALL   = 12,
    parameter int PG_LARGE   = 24
) (
    input  logic [EA_W-1:0] ea,
    input  logic            big_seg,
    input  logic            big_page,
    output logic [EA_W-1:0] seg_span,
    output logic [EA_W-1:0] page_addr,
    output logic [EA_W-1:0] page_idx
);
    localparam logic [EA_W-1:0] ONE = EA_W'(1);

    logic [EA_W-1:0] pg_span;
    logic [EA_W-1:0] keep_mask;

    // segment span and page span as single-bit weights
    always_comb begin
        seg_span  = big_seg  ? (ONE << SEG_LONG) : (ONE << SEG_SHORT);
        pg_span   = big_page ? (ONE << PG_LARGE) : (ONE << PG_SMALL);
        keep_mask = seg_span - pg_span;
        page_addr = ea & keep_mask;
        page_idx  = big_page ? (page_addr >> PG_LARGE) : (page_addr >> PG_SMALL);
    end
endmodule

// File: rtl/shg_hash.sv
module shg_hash #(
    parameter int EA_W     = 64,
    parameter int VSID_W   = 52,
    parameter int FOLD_SH  = 25,
    parameter int HASH_W   = 39
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [EA_W-1:0]   page_idx,
    input  logic              big_seg,
    output logic [HASH_W-1:0] hash
);
    localparam int PAD_W = EA_W - VSID_W;

    logic [EA_W-1:0] vsid_wide;
    logic [EA_W-1:0] fold_term;

    assign vsid_wide = {{PAD_W{1'b0}}, vsid};

    generate
        if (FOLD_SH > 0) begin : g_fold
            assign fold_term = big_seg ? (vsid_wide << FOLD_SH) : '0;
        end else begin : g_nofold
            assign fold_term = '0;
        end
    endgenerate

    assign hash = HASH_W'(vsid_wide ^ fold_term ^ page_idx);
endmodule

// File: rtl/shg_match.sv
module shg_match #(
    parameter int EA_W      = 64,
    parameter int ABBR_SH   = 16,
    parameter int ABBR_LOW  = 128
) (
    input  logic [EA_W-1:0] tag,
    input  logic [EA_W-1:0] page_addr,
    input  logic [EA_W-1:0] seg_span,
    output logic [EA_W-1:0] match
);
    localparam logic [EA_W-1:0] LOW_CUT = EA_W'(ABBR_LOW);

    logic [EA_W-1:0] abbr_mask;

    assign abbr_mask = seg_span - LOW_CUT;
    assign match     = tag | ((page_addr >> ABBR_SH) & abbr_mask);
endmodule

// File: rtl/shg_ctrl.sv
module shg_ctrl
    import shg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic rsp_ready,
    output logic req_ready,
    output logic load,
    output logic rsp_valid
);
    shg_state_e state_q;
    shg_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (req_valid) state_d = ST_FULL;       // accept
            end
            ST_FULL: begin
                if (rsp_ready && !req_valid) state_d = ST_EMPTY; // drain only
                // drain+accept or stall stay FULL
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_EMPTY) || rsp_ready;
        load      = req_valid && req_ready;
        rsp_valid = (state_q == ST_FULL);
    end
endmodule

// File: rtl/seg_hash_gen.sv
module seg_hash_gen
    import shg_pkg::*;
#(
    parameter int EA_W      = 64,
    parameter int VSID_W    = 52,
    parameter int VSID_TRIM = 12,
    parameter int HASH_W    = 39,
    parameter int SEG_SHORT = 28,
    parameter int SEG_LONG  = 40,
    parameter int PG_SMALL  = 12,
    parameter int PG_LARGE  = 24,
    parameter int FOLD_SH   = 25,
    parameter int ABBR_SH   = 16,
    parameter int ABBR_LOW  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [EA_W-1:0]   req_ea,
    input  logic              req_hit,
    input  logic              req_big_seg,
    input  logic              req_big_page,
    input  logic [VSID_W-1:0] req_vsid_field,
    input  logic              req_key_user,
    input  logic              req_key_sup,
    input  logic              req_noexec,
    input  logic [EA_W-1:0]   req_tag,
    input  logic              req_user,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [3:0]        rsp_status,
    output logic [VSID_W-1:0] rsp_vsid,
    output logic              rsp_key,
    output logic              rsp_noexec,
    output logic [HASH_W-1:0] rsp_hash,
    output logic [EA_W-1:0]   rsp_match
);
    logic              load;
    logic [VSID_W-1:0] vsid_c;
    logic              key_c;
    logic [EA_W-1:0]   seg_span_c;
    logic [EA_W-1:0]   page_addr_c;
    logic [EA_W-1:0]   page_idx_c;
    logic [HASH_W-1:0] hash_c;
    logic [EA_W-1:0]   match_c;

    shg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .rsp_ready (rsp_ready),
        .req_ready (req_ready),
        .load      (load),
        .rsp_valid (rsp_valid)
    );

    // VSID extraction and privilege key selection
    always_comb begin
        vsid_c = req_big_seg ? (req_vsid_field >> VSID_TRIM) : req_vsid_field;
        key_c  = req_user ? req_key_user : req_key_sup;
    end

    shg_geom #(
        .EA_W      (EA_W),
        .SEG_SHORT (SEG_SHORT),
        .SEG_LONG  (SEG_LONG),
        .PG_SMALL  (PG_SMALL),
        .PG_LARGE  (PG_LARGE)
    ) u_geom (
        .ea        (req_ea),
        .big_seg   (req_big_seg),
        .big_page  (req_big_page),
        .seg_span  (seg_span_c),
        .page_addr (page_addr_c),
        .page_idx  (page_idx_c)
    );

    shg_hash #(
        .EA_W    (EA_W),
        .VSID_W  (VSID_W),
        .FOLD_SH (FOLD_SH),
        .HASH_W  (HASH_W)
    ) u_hash (
        .vsid     (vsid_c),
        .page_idx (page_idx_c),
        .big_seg  (req_big_seg),
        .hash     (hash_c)
    );

    shg_match #(
        .EA_W     (EA_W),
        .ABBR_SH  (ABBR_SH),
        .ABBR_LOW (ABBR_LOW)
    ) u_match (
        .tag       (req_tag),
        .page_addr (page_addr_c),
        .seg_span  (seg_span_c),
        .match     (match_c)
    );

    // result register; a miss loads the fault status and clears data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_status <= SHG_ST_OK;
            rsp_vsid   <= '0;
            rsp_key    <= 1'b0;
            rsp_noexec <= 1'b0;
            rsp_hash   <= '0;
            rsp_match  <= '0;
        end else if (load) begin
            if (req_hit) begin
                rsp_status <= SHG_ST_OK;
                rsp_vsid   <= vsid_c;
                rsp_key    <= key_c;
                rsp_noexec <= req_noexec;
                rsp_hash   <= hash_c;
                rsp_match  <= match_c;
            end else begin
                rsp_status <= SHG_ST_MISS;
                rsp_vsid   <= '0;
                rsp_key    <= 1'b0;
                rsp_noexec <= 1'b0;
                rsp_hash   <= '0;
                rsp_match  <= '0;
            end
        end
    end
endmodule

// File: rtl/shg_checker.sv
module shg_checker #(
    parameter int EA_W      = 64,
    parameter int VSID_W    = 52,
    parameter int VSID_TRIM = 12,
    parameter int HASH_W    = 39
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_hit,
    input logic              req_big_seg,
    input logic              req_user,
    input logic              req_key_user,
    input logic              req_key_sup,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [3:0]        rsp_status,
    input logic [VSID_W-1:0] rsp_vsid,
    input logic              rsp_key,
    input logic              rsp_noexec,
    input logic [HASH_W-1:0] rsp_hash,
    input logic [EA_W-1:0]   rsp_match
);
    a_r1_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 4'b0000) |->
            (rsp_status == 4'b1011 && rsp_vsid == '0 && !rsp_key && !rsp_noexec
             && rsp_hash == '0 && rsp_match == '0));

    a_r2_long_vsid_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_hit && req_big_seg) |=>
            ((rsp_vsid >> (VSID_W - VSID_TRIM)) == '0));

    a_r3_key_select: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_hit) |=>
            (rsp_key == ($past(req_user) ? $past(req_key_user) : $past(req_key_sup))));

    a_r8_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    a_r8_empty_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);

    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_hash) && $stable(rsp_match) && $stable(rsp_vsid)
             && $stable(rsp_status) && $stable(rsp_key) && $stable(rsp_noexec)));
endmodule

bind seg_hash_gen shg_checker #(
    .EA_W      (EA_W),
    .VSID_W    (VSID_W),
    .VSID_TRIM (VSID_TRIM),
    .HASH_W    (HASH_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_hit      (req_hit),
    .req_big_seg  (req_big_seg),
    .req_user     (req_user),
    .req_key_user (req_key_user),
    .req_key_sup  (req_key_sup),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_status   (rsp_status),
    .rsp_vsid     (rsp_vsid),
    .rsp_key      (rsp_key),
    .rsp_noexec   (rsp_noexec),
    .rsp_hash     (rsp_hash),
    .rsp_match    (rsp_match)
);

// File: tb/tb_seg_hash_gen.sv
module tb_seg_hash_gen;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  status;
        logic [51:0] vsid;
        logic        key;
        logic        nx;
        logic [38:0] hash;
        logic [63:0] match;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_ea = '0;
    logic        req_hit = 1'b0;
    logic        req_big_seg = 1'b0;
    logic        req_big_page = 1'b0;
    logic [51:0] req_vsid_field = '0;
    logic        req_key_user = 1'b0;
    logic        req_key_sup = 1'b0;
    logic        req_noexec = 1'b0;
    logic [63:0] req_tag = '0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [3:0]  rsp_status;
    logic [51:0] rsp_vsid;
    logic        rsp_key;
    logic        rsp_noexec;
    logic [38:0] rsp_hash;
    logic [63:0] rsp_match;

    int checks = 0;
    int errors = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic  stall_mode = 1'b0;
    logic [7:0] stall_lfsr = 8'hA5;
    logic [63:0] ea_lfsr = 64'h1234_5678_9ABC_DEF1;

    seg_hash_gen dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // downstream ready, changed just after the edge
    always @(posedge clk) begin
        #1;
        stall_lfsr <= {stall_lfsr[6:0], stall_lfsr[7] ^ stall_lfsr[5] ^ stall_lfsr[4] ^ stall_lfsr[3]};
        rsp_ready  <= stall_mode ? stall_lfsr[0] : 1'b1;
    end

    function automatic exp_t model(input logic [63:0] ea, input logic hit, input logic bs,
                                   input logic bp, input logic [51:0] fld, input logic ku,
                                   input logic ks, input logic nx, input logic [63:0] tg,
                                   input logic usr);
        exp_t e;
        int s, p;
        logic [63:0] pa, pidx, v, h;
        e = '0;
        if (!hit) begin
            e.status = 4'b1011;
            return e;
        end
        s = bs ? 40 : 28;
        p = bp ? 24 : 12;
        pa = ea & ((64'd1 << s) - (64'd1 << p));
        pidx = pa >> p;
        v = bs ? {12'd0, fld} >> 12 : {12'd0, fld};
        h = bs ? (v ^ (v << 25) ^ pidx) : (v ^ pidx);
        e.vsid  = v[51:0];
        e.key   = usr ? ku : ks;
        e.nx    = nx;
        e.hash  = h[38:0];
        e.match = tg | ((pa >> 16) & ((64'd1 << s) - 64'h80));
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // driver: called at a negedge
    task automatic send(input logic [63:0] ea, input logic hit, input logic bs, input logic bp,
                        input logic [51:0] fld, input logic ku, input logic ks, input logic nx,
                        input logic [63:0] tg, input logic usr, input string req,
                        input bit use_fixed, input exp_t fixed);
        req_ea = ea; req_hit = hit; req_big_seg = bs; req_big_page = bp;
        req_vsid_field = fld; req_key_user = ku; req_key_sup = ks; req_noexec = nx;
        req_tag = tg; req_user = usr; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        exp_q.push_back(use_fixed ? fixed : model(ea, hit, bs, bp, fld, ku, ks, nx, tg, usr));
        tag_q.push_back(req);
        @(posedge clk);
        @(negedge clk);
        check(rsp_valid === 1'b1, "R8", "valid after accept", 128'(rsp_valid), 128'd1);
        req_valid = 1'b0;
    endtask

    // monitor / scoreboard
    exp_t held;
    logic was_stalled = 1'b0;
    always @(negedge clk) begin
        exp_t got, e;
        string t;
        if (rst_n) begin
            got = '{status: rsp_status, vsid: rsp_vsid, key: rsp_key, nx: rsp_noexec,
                    hash: rsp_hash, match: rsp_match};
            if (was_stalled && rsp_valid)
                check(got == held, "R9", "stall hold", 128'(got.hash), 128'(held.hash));
            if (rsp_valid && rsp_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected result", 128'(got.hash), 128'd0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(got.status == e.status, t, "status", 128'(got.status), 128'(e.status));
                    check(got.vsid == e.vsid, t, "vsid", 128'(got.vsid), 128'(e.vsid));
                    check({got.key, got.nx} == {e.key, e.nx}, t, "key/nx",
                          128'({got.key, got.nx}), 128'({e.key, e.nx}));
                    check(got.hash == e.hash, t, "hash", 128'(got.hash), 128'(e.hash));
                    check(got.match == e.match, t, "match", 128'(got.match), 128'(e.match));
                end
            end
            was_stalled = rsp_valid && !rsp_ready;
            held = got;
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired R8 actual=hung expected=done");
        summary();
    end

    initial begin
        exp_t hand;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(rsp_valid === 1'b0, "R10", "rsp_valid after reset", 128'(rsp_valid), 128'd0);
        check(req_ready === 1'b1, "R10", "req_ready after reset", 128'(req_ready), 128'd1);

        // R5 R7 hand-computed case: 256 MB, 4 KB, vsid 1
        hand = '0;
        hand.vsid = 52'd1; hand.key = 1'b1;
        hand.hash = 39'h2344; hand.match = 64'h200;
        send(64'h0000_0000_1234_5678, 1, 0, 0, 52'd1, 0, 1, 0, 64'd0, 0, "R5_R7_hand", 1, hand);

        // R1 miss with busy fields
        send(64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 1, '1, 1, 1, 1, '1, 1, "R1", 0, '0);

        // R2 R4 R6 corner addresses over all size combinations and privilege
        for (int c = 0; c < 16; c++) begin
            send(c[0] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_00AB_CDEF_0123,
                 1, c[1], c[2], 52'hF_EDCB_A987_6543, 1'b1, 1'b0, c[0], 64'hF000_0000_0000_0000,
                 c[3], c[1] ? "R6_R2_R4" : "R5_R2_R4", 0, '0);
        end

        // R3 key select both ways, R7 tag merge
        send(64'h0000_0012_3456_7000, 1, 0, 1, 52'h3_0000_0000_0ABC, 1, 0, 1, 64'h0F00, 1, "R3_user", 0, '0);
        send(64'h0000_0012_3456_7000, 1, 0, 1, 52'h3_0000_0000_0ABC, 1, 0, 1, 64'h0F00, 0, "R3_sup", 0, '0);
        send(64'h0000_FFFF_FFFF_FFFF, 1, 1, 0, 52'hF_FFFF_FFFF_FFFF, 0, 1, 0, 64'h7, 0, "R7", 0, '0);

        // R9 R8 back-to-back under downstream stalls, hits and misses mixed
        stall_mode = 1'b1;
        for (int i = 0; i < 40; i++) begin
            ea_lfsr = {ea_lfsr[62:0], ea_lfsr[63] ^ ea_lfsr[62] ^ ea_lfsr[60] ^ ea_lfsr[59]};
            send(ea_lfsr, (i % 7) != 3, ea_lfsr[5], ea_lfsr[9], ea_lfsr[51:0] ^ 52'h5_5555_0000_1111,
                 ea_lfsr[1], ea_lfsr[2], ea_lfsr[3], {ea_lfsr[31:0], 32'd0}, ea_lfsr[4], "R9", 0, '0);
        end
        stall_mode = 1'b0;

        // drain
        for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(negedge clk);
        check(exp_q.size() == 0, "R9", "all results delivered", 128'(exp_q.size()), 128'd0);
        repeat (2) @(negedge clk);
        check(rsp_valid === 1'b0, "R8", "empty after drain", 128'(rsp_valid), 128'd0);
        summary();
    end
endmodule